// File: doc/BRIEF.md
# Four-Digit Seven-Segment Scan Controller

This block drives a four-digit, common-anode, seven-segment display where all digits share one set of seven cathode lines and each digit has its own enable line. Because the cathodes are shared, only one digit can show a pattern at any instant. The controller therefore lights the digits one after another, in a fixed cyclic order, quickly enough that the eye sees all four lit at once.

Each digit takes a 4-bit value, which is shown as a hexadecimal glyph. A prescaler, set at elaboration time from the clock frequency and a requested refresh period, decides how long each digit stays lit. The requested period is clamped into the 1 ms to 16 ms window so that the display cannot flicker. A separate override parameter sets the slot length directly in clock cycles, so that short runs can reach every slot boundary. Between two digits the controller spends one clock cycle with every enable off, which stops the outgoing pattern from smearing onto the incoming digit.

Top module: `seg_scan_ctrl`

## Requirements
- R1: At most one bit of `dig_en_n` is low in any cycle, and a low bit selects its digit.
- R2: Digits are visited in the repeating order 0, 1, 2, 3, 0, … Enable bit i belongs to digit i, and the value of digit i sits in `digits[4i+3:4i]`.
- R3: Every slot lasts exactly S clock cycles: one cycle with all enables high, then S-1 cycles with that slot's enable low. One full refresh is 4·S cycles.
- R4: Between any two successive digits there is exactly one cycle in which all of `dig_en_n` is high.
- R5: `seg_n[0]` through `seg_n[6]` drive segments a through g, and a low bit lights its segment. The lit sets are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all, 9=abcdfg, A=abcefg, b=cdefg, C=adef, d=bcdeg, E=adefg, F=aefg.
- R6: `seg_n` shows the glyph of the current slot's digit value, as sampled at the previous clock edge. This includes the slot's blank cycle, so a value change appears one cycle later.
- R7: Without the override, S = (CLK_HZ/1000)·P/4000, where P is REFRESH_US clamped into [1000, 16000] microseconds. A request above 16 ms is cut to 16 ms, and one below 1 ms is raised to 1 ms.
- R8: When TEST_SLOT_CYCLES is nonzero, S equals TEST_SLOT_CYCLES and the refresh window is ignored.
- R9: A synchronous active-high `rst` sets every bit of `dig_en_n` and `seg_n` high at the next edge, and restarts the scan at digit 0.
- R10: Outputs are registered. The k-th edge after reset is released produces the output for count c=(k-1) mod S and digit ((k-1) div S) mod 4. When c=0 all enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| digits | input | 16 | Four 4-bit digit values; digit i is at bits 4i+3:4i |
| dig_en_n | output | 4 | Per-digit enables, active low |
| seg_n | output | 7 | Shared segment cathodes a..g, active low |

## Verification
The bench runs three instances side by side: one with a short override slot, one that requests a 40 ms refresh, and one that requests 0.1 ms. A prescaler that does not clamp would stretch the long instance past 16 ms, or squeeze the short one below 1 ms, and its slot boundaries would then drift from the model. Every cycle is compared against a timeline computed from the reset release, so several faults are caught:
- a missing blank cycle between digits, or an extra one;
- an off-by-one slot length;
- a wrong scan order, or a digit that never advances;
- a mis-indexed digit slice.

Hexadecimal values are swept on every digit, and random value changes are made mid-slot. These expose a wrong glyph entry, a swapped segment bit, and a segment path that lags by the wrong number of cycles. A reset applied in the middle of a slot must restart the scan at digit 0, beginning with a blank cycle.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

   localparam int unsigned SEG_W       = 7;
   localparam int unsigned NIBBLE_W    = 4;
   localparam int unsigned MIN_PER_US  = 1000;
   localparam int unsigned MAX_PER_US  = 16000;

   // lit-segment set, bit0 = a ... bit6 = g, active high
   function automatic logic [SEG_W-1:0] hex_glyph(input logic [NIBBLE_W-1:0] v);
      logic [SEG_W-1:0] g;
      case (v)
         4'h0: g = 7'b0111111;
         4'h1: g = 7'b0000110;
         4'h2: g = 7'b1011011;
         4'h3: g = 7'b1001111;
         4'h4: g = 7'b1100110;
         4'h5: g = 7'b1101101;
         4'h6: g = 7'b1111101;
         4'h7: g = 7'b0000111;
         4'h8: g = 7'b1111111;
         4'h9: g = 7'b1101111;
         4'hA: g = 7'b1110111;
         4'hB: g = 7'b1111100;
         4'hC: g = 7'b0111001;
         4'hD: g = 7'b1011110;
         4'hE: g = 7'b1111001;
         default: g = 7'b1110001;
      endcase
      return g;
   endfunction

   function automatic int unsigned clamp_period_us(input int unsigned req_us);
      if (req_us < MIN_PER_US) return MIN_PER_US;
      if (req_us > MAX_PER_US) return MAX_PER_US;
      return req_us;
   endfunction

   function automatic int unsigned slot_cycles(input longint unsigned clk_hz,
                                               input int unsigned     req_us,
                                               input int unsigned     ndig,
                                               input int unsigned     test_slot);
      longint unsigned per_ms;
      longint unsigned cyc;
      if (test_slot != 0) return test_slot;
      per_ms = clk_hz / 1000;
      cyc    = (per_ms * longint'(clamp_period_us(req_us))) / 1000;
      return int'(cyc / longint'(ndig));
   endfunction

endpackage

// File: rtl/seg_scan_prescaler.sv
module seg_scan_prescaler #(
   parameter int unsigned SLOT  = 8,
   localparam int unsigned CW   = (SLOT > 2) ? $clog2(SLOT) : 1
) (
   input  logic clk,
   input  logic rst,
   output logic slot_first,
   output logic slot_last
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (cnt_q == CW'(SLOT - 1))
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign slot_first = (cnt_q == '0);
   assign slot_last  = (cnt_q == CW'(SLOT - 1));
endmodule

// File: rtl/seg_scan_sequencer.sv
module seg_scan_sequencer #(
   parameter int unsigned NDIG = 4,
   localparam int unsigned IW  = (NDIG > 2) ? $clog2(NDIG) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          advance,
   output logic [IW-1:0] idx
);
   always_ff @(posedge clk) begin
      if (rst)
         idx <= '0;
      else if (advance)
         idx <= (idx == IW'(NDIG - 1)) ? '0 : idx + 1'b1;
   end
endmodule

// File: rtl/seg_scan_decoder.sv
module seg_scan_decoder
   import seg_scan_pkg::*;
#(
   parameter int unsigned NDIG = 4,
   localparam int unsigned IW  = (NDIG > 2) ? $clog2(NDIG) : 1
) (
   input  logic [NDIG*NIBBLE_W-1:0] digits,
   input  logic [IW-1:0]            idx,
   input  logic                     blank,
   output logic [NDIG-1:0]          en_n_d,
   output logic [SEG_W-1:0]         seg_n_d
);
   logic [NIBBLE_W-1:0] slice [NDIG];
   logic [NDIG-1:0]     hit;

   for (genvar g = 0; g < NDIG; g++) begin : g_dig
      assign slice[g] = digits[g*NIBBLE_W +: NIBBLE_W];
      assign hit[g]   = (idx == IW'(g));
   end

   assign en_n_d  = blank ? '1 : ~hit;
   assign seg_n_d = ~hex_glyph(slice[idx]);
endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
   import seg_scan_pkg::*;
#(
   parameter longint unsigned CLK_HZ          = 50_000_000,
   parameter int unsigned     REFRESH_US      = 8000,
   parameter int unsigned     TEST_SLOT_CYCLES = 0,
   parameter int unsigned     NUM_DIGITS      = 4,
   localparam int unsigned    SLOT_CYCLES     = slot_cycles(CLK_HZ, REFRESH_US, NUM_DIGITS, TEST_SLOT_CYCLES),
   localparam int unsigned    IW              = (NUM_DIGITS > 2) ? $clog2(NUM_DIGITS) : 1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [NUM_DIGITS*NIBBLE_W-1:0] digits,
   output logic [NUM_DIGITS-1:0]          dig_en_n,
   output logic [SEG_W-1:0]               seg_n
);
   if (NUM_DIGITS < 2) begin : g_bad_ndig
      $error("seg_scan_ctrl: NUM_DIGITS must be at least 2");
   end
   if (SLOT_CYCLES < 2) begin : g_bad_slot
      $error("seg_scan_ctrl: slot must hold a blank cycle plus one lit cycle");
   end
   if (TEST_SLOT_CYCLES == 0 && CLK_HZ < 1000) begin : g_bad_clk
      $error("seg_scan_ctrl: CLK_HZ too low for the refresh window");
   end

   logic          slot_first, slot_last;
   logic [IW-1:0] idx;
   logic [NUM_DIGITS-1:0] en_n_d;
   logic [SEG_W-1:0]      seg_n_d;

   seg_scan_prescaler #(.SLOT(SLOT_CYCLES)) u_pre (
      .clk        (clk),
      .rst        (rst),
      .slot_first (slot_first),
      .slot_last  (slot_last)
   );

   seg_scan_sequencer #(.NDIG(NUM_DIGITS)) u_seq (
      .clk     (clk),
      .rst     (rst),
      .advance (slot_last),
      .idx     (idx)
   );

   seg_scan_decoder #(.NDIG(NUM_DIGITS)) u_dec (
      .digits  (digits),
      .idx     (idx),
      .blank   (slot_first),
      .en_n_d  (en_n_d),
      .seg_n_d (seg_n_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dig_en_n <= '1;
         seg_n    <= '1;
      end else begin
         dig_en_n <= en_n_d;
         seg_n    <= seg_n_d;
      end
   end
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
   parameter int unsigned NDIG = 4,
   parameter int unsigned SLOT = 8,
   parameter int unsigned SW   = 7
) (
   input logic            clk,
   input logic            rst,
   input logic [NDIG-1:0] dig_en_n,
   input logic [SW-1:0]   seg_n
);
   localparam int unsigned IW = (NDIG > 2) ? $clog2(NDIG) : 1;

   logic          active;
   logic [IW-1:0] cur_idx;
   logic [IW-1:0] last_idx;
   logic [31:0]   run_len;

   assign active = (dig_en_n != '1);

   always_comb begin
      cur_idx = '0;
      for (int i = 0; i < NDIG; i++)
         if (!dig_en_n[i]) cur_idx = IW'(i);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         last_idx <= IW'(NDIG - 1);
         run_len  <= '0;
      end else begin
         if (active) last_idx <= cur_idx;
         run_len <= active ? run_len + 1 : '0;
      end
   end

   assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
      $countones(~dig_en_n) <= 1);

   assert_order_R2: assert property (@(posedge clk) disable iff (rst)
      (active && !$past(active)) |->
         (cur_idx == ((last_idx == IW'(NDIG - 1)) ? '0 : last_idx + 1'b1)));

   assert_slot_len_R3: assert property (@(posedge clk) disable iff (rst)
      (!active && $past(active) && !$past(rst)) |-> (run_len == SLOT - 1));

   assert_gap_R4: assert property (@(posedge clk) disable iff (rst)
      (active && $past(active) && !$past(rst)) |-> $stable(dig_en_n));

   assert_reset_R9: assert property (@(posedge clk)
      $past(rst) |-> (dig_en_n == '1 && seg_n == '1));
endmodule

bind seg_scan_ctrl seg_scan_chk #(
   .NDIG (NUM_DIGITS),
   .SLOT (SLOT_CYCLES),
   .SW   (seg_scan_pkg::SEG_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .dig_en_n (dig_en_n),
   .seg_n    (seg_n)
);

// File: tb/sim_seg_scan_ctrl.sv
module sim_seg_scan_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] digits = 16'h0;
   logic [3:0]  en0, en1, en2;
   logic [6:0]  sg0, sg1, sg2;

   int unsigned nchk  = 0;
   int unsigned nfail = 0;
   int unsigned k     = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   // R8: direct slot override of 6 cycles
   seg_scan_ctrl #(.TEST_SLOT_CYCLES(6)) u0 (
      .clk(clk), .rst(rst), .digits(digits), .dig_en_n(en0), .seg_n(sg0));
   // R7: 40 kHz clock, 40 ms request clamped to 16 ms -> slot 160
   seg_scan_ctrl #(.CLK_HZ(40_000), .REFRESH_US(40_000)) u1 (
      .clk(clk), .rst(rst), .digits(digits), .dig_en_n(en1), .seg_n(sg1));
   // R7: 40 kHz clock, 0.1 ms request raised to 1 ms -> slot 10
   seg_scan_ctrl #(.CLK_HZ(40_000), .REFRESH_US(100)) u2 (
      .clk(clk), .rst(rst), .digits(digits), .dig_en_n(en2), .seg_n(sg2));

   // R5 glyph table, active-high lit set, bit0 = a
   function automatic logic [6:0] lit(input logic [3:0] v);
      logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                             7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
      return t[v];
   endfunction

   function automatic logic [3:0] exp_en(input int unsigned kk, input int unsigned s);
      int unsigned c, i;
      if (kk == 0) return 4'hF;
      c = (kk - 1) % s;
      i = ((kk - 1) / s) % 4;
      if (c == 0) return 4'hF;
      return ~(4'b0001 << i);
   endfunction

   function automatic logic [6:0] exp_seg(input int unsigned kk, input int unsigned s,
                                          input logic [15:0] d);
      int unsigned i;
      if (kk == 0) return 7'h7F;
      i = ((kk - 1) / s) % 4;
      return ~lit(d[i*4 +: 4]);
   endfunction

   task automatic check(input string who, input string tag, input int unsigned s,
                        input logic [3:0] en, input logic [6:0] sg);
      logic [3:0] ee;
      logic [6:0] es;
      string t;
      ee = exp_en(k, s);
      es = exp_seg(k, s, digits);
      nchk++;
      if (en !== ee) begin
         nfail++;
         if (k == 0) t = "R9";
         else if (k == 1) t = "R10";
         else if (ee == 4'hF) t = "R4";
         else if ($countones(~en) > 1) t = "R1";
         else t = tag;
         $display("FAIL %s %s k=%0d dig_en_n actual=%b expected=%b", t, who, k, en, ee);
      end
      nchk++;
      if (sg !== es) begin
         nfail++;
         $display("FAIL %s R5 R6 k=%0d seg_n actual=%b expected=%b",
                  who, k, sg, es);
      end
   endtask

   task automatic step();
      @(posedge clk);
      if (rst) k = 0; else k++;
      @(negedge clk);
      check("u0", "R2 R3 R8", 6,   en0, sg0);
      check("u1", "R2 R3 R7", 160, en1, sg1);
      check("u2", "R2 R3 R7", 10,  en2, sg2);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R9: reset state
      repeat (3) step();
      @(negedge clk) rst = 1'b0;
      // directed: 1 then 7 on the first two digits (R2, R5)
      digits = {4'h3, 4'h2, 4'h7, 4'h1};
      repeat (700) step();
      // sweep every hex value on all digits (R5)
      for (int v = 0; v < 16; v++) begin
         digits = {4{v[3:0]}};
         repeat (30) step();
      end
      // random values changed mid-slot (R6)
      for (int n = 0; n < 2000; n++) begin
         if ($urandom_range(7) == 0) digits = 16'($urandom);
         step();
      end
      // mid-slot reset, then restart from digit 0 (R9, R10)
      rst = 1'b1;
      repeat (2) step();
      rst = 1'b0;
      for (int n = 0; n < 700; n++) begin
         if ($urandom_range(5) == 0) digits = 16'($urandom);
         step();
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule